// File: doc/BRIEF.md
# Capacitive Touch Charge-Transfer Sequencer

This block paces a capacitive touch measurement. One measurement is a sequence of identical cycles. A cycle is a charge phase, then an optional extended charge phase, then a transfer phase. The charge and transfer phases are timed by a phase clock, which is the system clock divided by a power of two. The extended charge phase has its own integer divider. The block drives per-pin charge and transfer enables toward the pad logic. The pads are modelled as one digital comparator input per group.

Up to six groups of four pins are measured at the same time. A shared counter numbers the transfer phases. Each enabled group stops at the first transfer phase in which its comparator reads high, keeps that number as its count and raises its complete bit. The sequence ends with a one-clock done pulse when every enabled group has completed. It ends with a one-clock error pulse if the shared counter reaches the programmed maximum first.

Timing settings and group enables are captured when a sequence starts. Channel and sample pin maps are used live, because they only shape the pin enables.

Top module: `touch_acq_seq`

## Requirements
- R1: With phase exponent K, charge length field C and transfer length field T, each cycle without extension lasts (C+1)·2^K + (T+1)·2^K system clocks. The done or error pulse is visible N·(cycle length) clocks after the clock edge that accepts start, where N is the final cycle number.
- R2: When the extension enable is 1, an extended charge phase of (L+1)·(D+1) system clocks follows each charge phase, where L is the extension length field and D is the extension divider field. The charge enables stay asserted during this phase.
- R3: An enabled group completes on the first transfer phase whose final clock sees its comparator input high. Its count equals the 1-based number of that transfer phase.
- R4: A group whose enable bit is 0 never completes and its count stays 0, whatever its comparator input does.
- R5: The sequence ends with seq_done high for exactly one clock once every enabled group has completed, and busy is low from that clock on. With no group enabled, it ends after the first cycle.
- R6: The maximum field S selects a limit of 2^(8+S)−1, and values above 6 act as 6. If the limit is reached with any enabled group unfinished, max_err pulses for one clock instead of seq_done. In that case the unfinished groups keep complete = 0 and count = 0.
- R7: If the last unfinished group completes on the transfer phase that reaches the limit, the result is seq_done with no max_err.
- R8: An accepted start clears all counts and complete bits. A start while busy is ignored.
- R9: Changing timing fields, the maximum field, the extension enable or the group enables while busy has no effect on the running sequence.
- R10: Pin i belongs to group i/4. During charge and extended charge, pin_charge[i] = channel[i] and the group is enabled. During transfer, pin_xfer[i] = (channel[i] or sample[i]) and the group is enabled. The two enables are never high together.
- R11: While idle, pin_park_low[i] = channel[i] or sample[i] when the float select is 0, and 0 when it is 1. While busy, pin_park_low is 0 and, while idle, no charge or transfer enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken when idle |
| cfg_div_exp | input | 4 | Phase clock exponent K (divide by 2^K) |
| cfg_charge_len | input | 4 | Charge length field, C+1 phase periods |
| cfg_xfer_len | input | 4 | Transfer length field, T+1 phase periods |
| cfg_max_sel | input | 3 | Cycle limit select S |
| cfg_ext_en | input | 1 | Extended charge phase enable |
| cfg_ext_div | input | 3 | Extended clock divider field, divide by D+1 |
| cfg_ext_len | input | 7 | Extended phase length, L+1 extended periods |
| cfg_idle_float | input | 1 | 1 leaves pins floating while idle, 0 parks them low |
| cfg_grp_en | input | 6 | Group enables |
| cfg_chan_pins | input | 24 | Channel pin map, bit i = group i/4, pin i%4 |
| cfg_samp_pins | input | 24 | Sample pin map, same bit layout |
| sample_in | input | 6 | Per-group comparator inputs |
| busy | output | 1 | Sequence in progress |
| pin_charge | output | 24 | Per-pin charge enable |
| pin_xfer | output | 24 | Per-pin transfer enable |
| pin_park_low | output | 24 | Per-pin idle drive-low enable |
| grp_done | output | 6 | Per-group complete bits |
| grp_count | output | 84 | Per-group counts, 14 bits each, group g at [14g +: 14] |
| seq_done | output | 1 | One-clock pulse on normal completion |
| max_err | output | 1 | One-clock pulse when the cycle limit is hit |

## Verification
Group completion and the cycle limit can fall on the same transfer phase. The bench sets the smallest limit, 255 cycles, and trips the only enabled group on transfer phase 255. Completion must win: the result is seq_done, a count of 255 and no error pulse. A second run leaves one group silent, so the limit applies. That run must give max_err, with only the tripped group complete. Both runs are judged by a scoreboard entry that predicts the pulse kind, the masks, the counts and the exact clock of the end pulse.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CHARGE = 2'd1,
      ST_EXTEND = 2'd2,
      ST_XFER   = 2'd3
   } tsq_state_e;
endpackage

// File: rtl/tsq_tick_gen.sv
module tsq_tick_gen #(
   parameter int PRE_W     = 4,
   parameter int EXT_DIV_W = 3,
   parameter bit HAS_EXT   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic [PRE_W-1:0]     div_exp,
   input  logic [EXT_DIV_W-1:0] ext_div,
   output logic                 ph_tick,
   output logic                 ext_tick
);
   localparam int PCNT_W = (1 << PRE_W) - 1;

   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] pmask;

   // low K bits all ones marks the last clock of a phase period
   assign pmask   = ~({PCNT_W{1'b1}} << div_exp);
   assign ph_tick = (pcnt & pmask) == pmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
   end

   generate
      if (HAS_EXT) begin : g_ext
         logic [EXT_DIV_W-1:0] ecnt;
         assign ext_tick = (ecnt == ext_div);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   ecnt <= '0;
            else if (restart || ext_tick) ecnt <= '0;
            else                          ecnt <= ecnt + 1'b1;
         end
      end else begin : g_no_ext
         assign ext_tick = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tsq_group_slot.sv
module tsq_group_slot #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             enable,
   input  logic             eval,
   input  logic             hit,
   input  logic [CNT_W-1:0] cyc_num,
   output logic             done,
   output logic [CNT_W-1:0] count,
   output logic             finished
);
   // a disabled slot counts as finished so it never holds the sequence open
   assign finished = !enable || done || hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         count <= '0;
      end else if (clear) begin
         done  <= 1'b0;
         count <= '0;
      end else if (eval && enable && !done && hit) begin
         done  <= 1'b1;
         count <= cyc_num;
      end
   end
endmodule

// File: rtl/tsq_pin_map.sv
module tsq_pin_map
   import tsq_pkg::*;
#(
   parameter int NUM_GROUPS     = 6,
   parameter int PINS_PER_GROUP = 4,
   localparam int NPINS         = NUM_GROUPS * PINS_PER_GROUP
) (
   input  tsq_state_e            state,
   input  logic [NUM_GROUPS-1:0] grp_en,
   input  logic [NPINS-1:0]      chan,
   input  logic [NPINS-1:0]      samp,
   input  logic                  idle_float,
   output logic [NPINS-1:0]      charge,
   output logic [NPINS-1:0]      xfer,
   output logic [NPINS-1:0]      park
);
   logic in_charge, in_xfer, in_idle;
   assign in_charge = (state == ST_CHARGE) || (state == ST_EXTEND);
   assign in_xfer   = (state == ST_XFER);
   assign in_idle   = (state == ST_IDLE);

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         for (genvar p = 0; p < PINS_PER_GROUP; p++) begin : g_pin
            localparam int IDX = g * PINS_PER_GROUP + p;
            assign charge[IDX] = in_charge && grp_en[g] && chan[IDX];
            assign xfer[IDX]   = in_xfer && grp_en[g] && (chan[IDX] || samp[IDX]);
            assign park[IDX]   = in_idle && !idle_float && (chan[IDX] || samp[IDX]);
         end
      end
   endgenerate
endmodule

// File: rtl/touch_acq_seq.sv
module touch_acq_seq
   import tsq_pkg::*;
#(
   parameter int NUM_GROUPS     = 6,
   parameter int PINS_PER_GROUP = 4,
   parameter int CNT_W          = 14,
   parameter int MIN_LOG        = 8,
   parameter int PRE_W          = 4,
   parameter int DUR_W          = 4,
   parameter int MAXSEL_W       = 3,
   parameter int EXT_DIV_W      = 3,
   parameter int EXT_LEN_W      = 7,
   parameter bit HAS_EXT        = 1'b1,
   localparam int NPINS         = NUM_GROUPS * PINS_PER_GROUP
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [PRE_W-1:0]            cfg_div_exp,
   input  logic [DUR_W-1:0]            cfg_charge_len,
   input  logic [DUR_W-1:0]            cfg_xfer_len,
   input  logic [MAXSEL_W-1:0]         cfg_max_sel,
   input  logic                        cfg_ext_en,
   input  logic [EXT_DIV_W-1:0]        cfg_ext_div,
   input  logic [EXT_LEN_W-1:0]        cfg_ext_len,
   input  logic                        cfg_idle_float,
   input  logic [NUM_GROUPS-1:0]       cfg_grp_en,
   input  logic [NPINS-1:0]            cfg_chan_pins,
   input  logic [NPINS-1:0]            cfg_samp_pins,
   input  logic [NUM_GROUPS-1:0]       sample_in,
   output logic                        busy,
   output logic [NPINS-1:0]            pin_charge,
   output logic [NPINS-1:0]            pin_xfer,
   output logic [NPINS-1:0]            pin_park_low,
   output logic [NUM_GROUPS-1:0]       grp_done,
   output logic [NUM_GROUPS*CNT_W-1:0] grp_count,
   output logic                        seq_done,
   output logic                        max_err
);
   localparam int SEL_TOP = CNT_W - MIN_LOG;
   localparam int PH_W    = (EXT_LEN_W > DUR_W) ? EXT_LEN_W : DUR_W;

   generate
      if (SEL_TOP < 0) begin : g_bad_cnt
         $error("CNT_W must be at least MIN_LOG");
      end
      if (SEL_TOP >= (1 << MAXSEL_W)) begin : g_bad_sel
         $error("MAXSEL_W too narrow for the limit range");
      end
      if (PRE_W < 1 || PRE_W > 5) begin : g_bad_pre
         $error("PRE_W out of range");
      end
      if (NUM_GROUPS < 1 || PINS_PER_GROUP < 1) begin : g_bad_geom
         $error("group geometry must be non-empty");
      end
   endgenerate

   tsq_state_e state_q, state_d;
   logic [PH_W-1:0]       phase_q;
   logic [CNT_W-1:0]      cyc_q, cyc_next, max_q;
   logic [PRE_W-1:0]      kexp_q;
   logic [DUR_W-1:0]      clen_q, tlen_q;
   logic                  ext_en_q;
   logic [EXT_DIV_W-1:0]  ediv_q;
   logic [EXT_LEN_W-1:0]  elen_q;
   logic [NUM_GROUPS-1:0] en_q, fin_vec;
   logic [MAXSEL_W-1:0]   sel_c;
   logic start_acc, phase_end, step_en, eval, all_fin, at_max, ph_tick, ext_tick;
   logic seq_done_q, max_err_q;

   assign start_acc = start && (state_q == ST_IDLE);
   assign cyc_next  = cyc_q + 1'b1;
   assign eval      = (state_q == ST_XFER) && phase_end;
   assign all_fin   = &fin_vec;
   assign at_max    = (cyc_next == max_q);
   assign sel_c     = (cfg_max_sel > MAXSEL_W'(SEL_TOP)) ? MAXSEL_W'(SEL_TOP) : cfg_max_sel;

   tsq_tick_gen #(.PRE_W(PRE_W), .EXT_DIV_W(EXT_DIV_W), .HAS_EXT(HAS_EXT)) u_ticks (
      .clk(clk), .rst_n(rst_n), .restart(start_acc || phase_end),
      .div_exp(kexp_q), .ext_div(ediv_q), .ph_tick(ph_tick), .ext_tick(ext_tick)
   );

   always_comb begin
      phase_end = 1'b0;
      step_en   = 1'b0;
      unique case (state_q)
         ST_CHARGE: begin
            phase_end = ph_tick && (phase_q == PH_W'(clen_q));
            step_en   = ph_tick;
         end
         ST_EXTEND: begin
            phase_end = ext_tick && (phase_q == PH_W'(elen_q));
            step_en   = ext_tick;
         end
         ST_XFER: begin
            phase_end = ph_tick && (phase_q == PH_W'(tlen_q));
            step_en   = ph_tick;
         end
         default: ;
      endcase
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_acc) state_d = ST_CHARGE;
         ST_CHARGE: if (phase_end) state_d = ext_en_q ? ST_EXTEND : ST_XFER;
         ST_EXTEND: if (phase_end) state_d = ST_XFER;
         ST_XFER:   if (phase_end) state_d = (all_fin || at_max) ? ST_IDLE : ST_CHARGE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= '0;
         cyc_q      <= '0;
         seq_done_q <= 1'b0;
         max_err_q  <= 1'b0;
         kexp_q     <= '0;
         clen_q     <= '0;
         tlen_q     <= '0;
         ext_en_q   <= 1'b0;
         ediv_q     <= '0;
         elen_q     <= '0;
         max_q      <= '1;
         en_q       <= '0;
      end else begin
         state_q    <= state_d;
         seq_done_q <= eval && all_fin;
         max_err_q  <= eval && !all_fin && at_max;
         if (start_acc || phase_end) phase_q <= '0;
         else if (step_en)           phase_q <= phase_q + 1'b1;
         if (start_acc)  cyc_q <= '0;
         else if (eval)  cyc_q <= cyc_next;
         if (start_acc) begin
            kexp_q   <= cfg_div_exp;
            clen_q   <= cfg_charge_len;
            tlen_q   <= cfg_xfer_len;
            ext_en_q <= HAS_EXT && cfg_ext_en;
            ediv_q   <= cfg_ext_div;
            elen_q   <= cfg_ext_len;
            max_q    <= {CNT_W{1'b1}} >> (MAXSEL_W'(SEL_TOP) - sel_c);
            en_q     <= cfg_grp_en;
         end
      end
   end

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
         tsq_group_slot #(.CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .clear(start_acc), .enable(en_q[g]),
            .eval(eval), .hit(sample_in[g]), .cyc_num(cyc_next),
            .done(grp_done[g]), .count(grp_count[g*CNT_W +: CNT_W]),
            .finished(fin_vec[g])
         );
      end
   endgenerate

   tsq_pin_map #(.NUM_GROUPS(NUM_GROUPS), .PINS_PER_GROUP(PINS_PER_GROUP)) u_pins (
      .state(state_q), .grp_en(en_q), .chan(cfg_chan_pins), .samp(cfg_samp_pins),
      .idle_float(cfg_idle_float), .charge(pin_charge), .xfer(pin_xfer), .park(pin_park_low)
   );

   assign busy     = (state_q != ST_IDLE);
   assign seq_done = seq_done_q;
   assign max_err  = max_err_q;
endmodule

// File: rtl/touch_acq_seq_chk.sv
module touch_acq_seq_chk #(
   parameter int NPINS      = 24,
   parameter int NUM_GROUPS = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  busy,
   input logic [NPINS-1:0]      pin_charge,
   input logic [NPINS-1:0]      pin_xfer,
   input logic [NPINS-1:0]      pin_park_low,
   input logic [NUM_GROUPS-1:0] grp_done,
   input logic                  seq_done,
   input logic                  max_err
);
   p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_done && max_err));

   p_enables_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_charge & pin_xfer) == '0);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pin_charge == '0 && pin_xfer == '0));

   p_busy_no_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> pin_park_low == '0);

   p_end_is_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done || max_err) |-> !busy);

   p_fall_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (seq_done || max_err));

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && grp_done == '0));

   p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(grp_done));
endmodule

bind touch_acq_seq touch_acq_seq_chk #(.NPINS(NPINS), .NUM_GROUPS(NUM_GROUPS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .pin_charge(pin_charge), .pin_xfer(pin_xfer), .pin_park_low(pin_park_low),
   .grp_done(grp_done), .seq_done(seq_done), .max_err(max_err)
);

// File: tb/touch_acq_seq_bench.sv
`timescale 1ns/1ps
module touch_acq_seq_bench;
   localparam int PERIOD = 10;
   localparam int NG = 6;
   localparam int CW = 14;
   localparam int NP = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [3:0] cfg_div_exp = '0, cfg_charge_len = '0, cfg_xfer_len = '0;
   logic [2:0] cfg_max_sel = '0, cfg_ext_div = '0;
   logic cfg_ext_en = 1'b0, cfg_idle_float = 1'b0;
   logic [6:0] cfg_ext_len = '0;
   logic [NG-1:0] cfg_grp_en = '0, sample_in;
   logic [NP-1:0] cfg_chan_pins = 24'h5A5A5A, cfg_samp_pins = 24'h828282;
   logic busy, seq_done, max_err;
   logic [NP-1:0] pin_charge, pin_xfer, pin_park_low;
   logic [NG-1:0] grp_done;
   logic [NG*CW-1:0] grp_count;

   always #(PERIOD/2) clk = ~clk;

   touch_acq_seq u_touch_acq_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_div_exp(cfg_div_exp),
      .cfg_charge_len(cfg_charge_len), .cfg_xfer_len(cfg_xfer_len),
      .cfg_max_sel(cfg_max_sel), .cfg_ext_en(cfg_ext_en), .cfg_ext_div(cfg_ext_div),
      .cfg_ext_len(cfg_ext_len), .cfg_idle_float(cfg_idle_float),
      .cfg_grp_en(cfg_grp_en), .cfg_chan_pins(cfg_chan_pins),
      .cfg_samp_pins(cfg_samp_pins), .sample_in(sample_in), .busy(busy),
      .pin_charge(pin_charge), .pin_xfer(pin_xfer), .pin_park_low(pin_park_low),
      .grp_done(grp_done), .grp_count(grp_count), .seq_done(seq_done), .max_err(max_err)
   );

   typedef struct {
      logic [NG-1:0]    done;
      logic [NG*CW-1:0] cnt;
      logic             err;
      longint           elapsed;
      string            tag;
   } exp_t;

   exp_t   sb[$];
   int     checks = 0;
   int     errors = 0;
   int     trip[NG];
   longint t0 = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic logic [NP-1:0] expand(input logic [NG-1:0] en);
      logic [NP-1:0] m;
      for (int i = 0; i < NP; i++) m[i] = en[i/4];
      return m;
   endfunction

   // comparator model: group g reads high from transfer phase trip[g] onward
   int xidx = 0;
   bit xprev = 1'b0;
   always @(negedge clk) begin
      if (!busy) begin
         xidx = 0;
         xprev = 1'b0;
      end else begin
         if ((|pin_xfer) && !xprev) xidx++;
         xprev = |pin_xfer;
      end
      for (int g = 0; g < NG; g++) sample_in[g] <= (trip[g] != 0) && (xidx >= trip[g]);
   end

   // monitor: pop and compare at each end pulse
   initial begin
      forever begin
         @(negedge clk);
         if (seq_done || max_err) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R5", "unexpected end pulse", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(max_err == e.err, e.tag, "error pulse", max_err, e.err);
               chk(seq_done == !e.err, e.tag, "done pulse", seq_done, !e.err);
               chk(grp_done == e.done, e.tag, "complete mask", grp_done, e.done);
               chk(grp_count == e.cnt, e.tag, "counts", grp_count, e.cnt);
               chk(($time - t0) / PERIOD == e.elapsed, e.tag, "end clock",
                   ($time - t0) / PERIOD, e.elapsed);
            end
            @(negedge clk);
            chk(!seq_done && !max_err, "R5", "pulse width", {seq_done, max_err}, 0);
         end
      end
   end

   task automatic launch(input int k, input int c, input int t, input int ee,
                         input int ed, input int el, input int ms,
                         input logic [NG-1:0] en, input string tag);
      exp_t e;
      longint clen, maxv, nend;
      bit fin;
      int mx;
      cfg_div_exp = 4'(k);  cfg_charge_len = 4'(c); cfg_xfer_len = 4'(t);
      cfg_ext_en = ee[0];   cfg_ext_div = 3'(ed);   cfg_ext_len = 7'(el);
      cfg_max_sel = 3'(ms); cfg_grp_en = en;
      clen = longint'(c + 1) * (1 << k) + longint'(t + 1) * (1 << k)
           + (ee != 0 ? longint'(el + 1) * (ed + 1) : 0);
      maxv = (longint'(1) << (8 + (ms > 6 ? 6 : ms))) - 1;
      fin = 1'b1;
      mx = 0;
      for (int g = 0; g < NG; g++) if (en[g]) begin
         if (trip[g] == 0 || trip[g] > maxv) fin = 1'b0;
         else if (trip[g] > mx) mx = trip[g];
      end
      nend = (en == '0) ? 1 : (fin ? mx : maxv);
      e.err = !fin;
      e.done = '0;
      e.cnt = '0;
      for (int g = 0; g < NG; g++)
         if (en[g] && trip[g] != 0 && trip[g] <= nend) begin
            e.done[g] = 1'b1;
            e.cnt[g*CW +: CW] = CW'(trip[g]);
         end
      e.elapsed = nend * clen + 1;
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b1;
      t0 = $time;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (sb.size() != 0 || busy);
      repeat (2) @(negedge clk);
   endtask

   task automatic set_trips(input int a0, input int a1, input int a2,
                            input int a3, input int a4, input int a5);
      trip[0] = a0; trip[1] = a1; trip[2] = a2;
      trip[3] = a3; trip[4] = a4; trip[5] = a5;
   endtask

   initial begin
      #(PERIOD * 150000);
      chk(1'b0, "R5", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      set_trips(0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state, idle parking (R11)
      chk(!busy && grp_done == '0 && grp_count == '0, "R8", "reset state", busy, 0);
      chk(pin_park_low == (cfg_chan_pins | cfg_samp_pins), "R11", "park low",
          pin_park_low, cfg_chan_pins | cfg_samp_pins);
      cfg_idle_float = 1'b1;
      @(negedge clk);
      chk(pin_park_low == '0, "R11", "float idle", pin_park_low, 0);
      cfg_idle_float = 1'b0;

      // R3/R1: all groups, staggered trips, fastest timing
      set_trips(1, 2, 3, 4, 5, 6);
      launch(0, 0, 0, 0, 0, 0, 0, 6'h3F, "R3");
      wait_idle();

      // R4/R1: disabled groups read high but must stay clear
      set_trips(3, 1, 7, 1, 5, 1);
      launch(2, 3, 1, 0, 0, 0, 0, 6'h15, "R4");
      wait_idle();

      // R2: extended charge phase, checked on the pins too
      set_trips(2, 2, 0, 0, 0, 0);
      launch(1, 0, 2, 1, 2, 4, 0, 6'h03, "R2");
      repeat (3) @(negedge clk);
      chk(pin_charge == (cfg_chan_pins & expand(6'h03)) && pin_xfer == '0, "R2",
          "charge held in extension", pin_charge, cfg_chan_pins & expand(6'h03));
      wait_idle();

      // R10/R11: pin enables per phase
      set_trips(1, 0, 1, 0, 0, 1);
      launch(3, 0, 0, 0, 0, 0, 0, 6'h25, "R10");
      chk(pin_charge == (cfg_chan_pins & expand(6'h25)) && pin_xfer == '0, "R10",
          "charge enables", pin_charge, cfg_chan_pins & expand(6'h25));
      chk(pin_park_low == '0, "R11", "no park while busy", pin_park_low, 0);
      repeat (8) @(negedge clk);
      chk(pin_xfer == ((cfg_chan_pins | cfg_samp_pins) & expand(6'h25)) && pin_charge == '0,
          "R10", "transfer enables", pin_xfer, (cfg_chan_pins | cfg_samp_pins) & expand(6'h25));
      wait_idle();

      // R6: limit of 255 reached with one group silent
      set_trips(10, 0, 0, 0, 0, 0);
      launch(0, 0, 0, 0, 0, 0, 0, 6'h03, "R6");
      wait_idle();

      // R7: last group trips exactly on the limit cycle
      set_trips(255, 0, 0, 0, 0, 0);
      launch(0, 0, 0, 0, 0, 0, 0, 6'h01, "R7");
      wait_idle();

      // R5: no group enabled ends after one cycle; previous done bits cleared (R8)
      set_trips(0, 0, 0, 0, 0, 0);
      launch(0, 1, 1, 0, 0, 0, 0, 6'h00, "R5");
      chk(grp_done == '0 && grp_count == '0, "R8", "cleared on start", grp_done, 0);
      wait_idle();

      // R9/R8: configuration changes and a second start while busy
      set_trips(2, 1, 3, 2, 1, 4);
      launch(0, 1, 0, 0, 0, 0, 0, 6'h3F, "R9");
      repeat (3) @(negedge clk);
      cfg_charge_len = 4'd9;
      cfg_grp_en = 6'h00;
      cfg_ext_en = 1'b1;
      cfg_div_exp = 4'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();

      // R6: select 7 behaves as select 6, limit 16383
      set_trips(0, 0, 0, 0, 0, 0);
      launch(0, 0, 0, 0, 0, 0, 7, 6'h01, "R6");
      wait_idle();

      finish_run();
   end
endmodule